// File: doc/BRIEF.md
# Branch Execution Trace Encoder

This block sits beside a processor's retire stage and turns the branch events it sees into a compact stream of 32-bit trace frames. An offline debugger reads this stream alongside the program image and rebuilds the control flow. Frames are produced only where control flow cannot be read from the image. A conditional branch yields one taken/not-taken atom. A branch whose destination comes from a register or a return yields a full PC. A zero-overhead loop yields its trip count once, when the loop starts.

Tracing is opened by a start pulse, which emits an anchor frame holding the fetch-stage PC. It is closed by a stop pulse, which flushes pending atoms in a final frame marked with TLAST. Up to eight atoms are packed into one frame. Frames wait in a small FIFO in front of an AXI4-Stream master. When the FIFO has no room, new frames are dropped and a sticky overflow flag is raised.

Top module: `brtrace_enc`

## Requirements
- R1: After reset, `m_tvalid` and `ovf` are 0.
- R2: A start pulse while idle emits a Start frame: bits 31:29 = 3'b001, bits 13:0 = `fetch_pc` in that cycle, all other bits 0. Branch and loop inputs in that cycle are ignored.
- R3: While tracing, each conditional branch (`br_kind` 0 = conditional direct, 1 = conditional indirect) adds one atom (1 = taken, 0 = not taken). The atom frame has bits 31:29 = 3'b010, bits 27:24 = atom count, and bit i = the i-th atom, oldest at bit 0. The frame is sent as soon as the count reaches 8.
- R4: An unconditional direct branch (`br_kind` 2) produces no frame. No unconditional branch or return adds an atom.
- R5: A return (`br_kind` 4) or an unconditional indirect branch (`br_kind` 3) emits a New_PC frame: bits 31:29 = 3'b011, bits 13:0 = `br_target`, all other bits 0.
- R6: A conditional indirect branch emits only its atom and never a New_PC frame, even when taken.
- R7: A loop start pulse emits one LC frame: bits 31:29 = 3'b100, bit 28 = 0, bits 27:0 = `loop_trips`.
- R8: Pending atoms are flushed into an atom frame before any New_PC or LC frame. Within one cycle the order is atom, New_PC, LC.
- R9: A stop pulse while tracing emits one atom frame holding the pending atoms (count may be 0) with `m_tlast` = 1. No other frame carries TLAST. While idle, all events produce no frames.
- R10: A frame that finds the FIFO full is dropped and `ovf` is set. `ovf` stays set until the next accepted start pulse. Stored frames keep their order.
- R11: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_start | input | 1 | Start tracing (pulse) |
| trc_stop | input | 1 | Stop tracing (pulse) |
| fetch_pc | input | PCW | Current fetch-stage PC |
| br_valid | input | 1 | Branch resolved this cycle |
| br_kind | input | 3 | Branch kind: 0 cond direct, 1 cond indirect, 2 uncond direct, 3 uncond indirect, 4 return |
| br_taken | input | 1 | Conditional branch taken |
| br_target | input | PCW | Destination PC |
| loop_start | input | 1 | Zero-overhead loop entered |
| loop_trips | input | TCW | Initial trip count |
| m_tvalid | output | 1 | Stream frame valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Trace frame |
| m_tlast | output | 1 | Last frame of a trace session |
| ovf | output | 1 | Sticky frame-drop flag |

## Verification
On every cycle, the assertions check that the output holds during backpressure, that LC frames keep bit 28 clear, that no atom frame claims more than eight atoms, that nothing is written while idle, and that the overflow flag stays set. Other behaviour can be shown only by the bench scenarios, which compare the frame sequence against a model: the per-kind framing rules, atom packing and bit order, flush ordering within a cycle, the fetch-PC anchor, TLAST on the stop frame, and exactly which frames survive an overflow.

// File: rtl/brtrace_enc.sv
module brtrace_enc #(
  parameter int PCW   = 14,
  parameter int TCW   = 28,
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trc_start,
  input  logic           trc_stop,
  input  logic [PCW-1:0] fetch_pc,
  input  logic           br_valid,
  input  logic [2:0]     br_kind,
  input  logic           br_taken,
  input  logic [PCW-1:0] br_target,
  input  logic           loop_start,
  input  logic [TCW-1:0] loop_trips,
  output logic           m_tvalid,
  input  logic           m_tready,
  output logic [31:0]    m_tdata,
  output logic           m_tlast,
  output logic           ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  localparam logic [2:0] T_START = 3'b001;
  localparam logic [2:0] T_ATOM  = 3'b010;
  localparam logic [2:0] T_NPC   = 3'b011;
  localparam logic [2:0] T_LC    = 3'b100;

  logic          act;
  logic [3:0]    acnt;
  logic [7:0]    abits;
  logic [32:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          ovf_q;

  logic          start_ev, stop_ev, run;
  logic          is_cond, want_pc;
  logic [3:0]    n_cnt;
  logic [7:0]    n_bits;
  logic          flush;
  logic [32:0]   cand [3];
  logic [2:0]    cval;
  logic [2:0]    we;
  logic [AW-1:0] pos [3];
  logic [CW-1:0] nwr, space;
  logic          drop, pop;

  function automatic logic [31:0] atom_frame(input logic [3:0] c, input logic [7:0] b);
    return {T_ATOM, 1'b0, c, 16'b0, b};
  endfunction

  assign start_ev = trc_start && !act;
  assign stop_ev  = trc_stop && act;
  assign run      = act && !stop_ev;
  assign is_cond  = br_valid && (br_kind == 3'd0 || br_kind == 3'd1);
  assign want_pc  = br_valid && (br_kind == 3'd3 || br_kind == 3'd4);
  assign n_cnt    = acnt + {3'b0, is_cond};
  assign n_bits   = is_cond ? (abits | (8'(br_taken) << acnt[2:0])) : abits;
  assign flush    = run && n_cnt != 4'd0 && (n_cnt == 4'd8 || want_pc || loop_start);

  always_comb begin
    cand[0] = '0;
    cval[0] = 1'b0;
    if (start_ev) begin
      cand[0] = {1'b0, T_START, {(29-PCW){1'b0}}, fetch_pc};
      cval[0] = 1'b1;
    end else if (stop_ev) begin
      cand[0] = {1'b1, atom_frame(acnt, abits)};
      cval[0] = 1'b1;
    end else if (flush) begin
      cand[0] = {1'b0, atom_frame(n_cnt, n_bits)};
      cval[0] = 1'b1;
    end
    cand[1] = {1'b0, T_NPC, {(29-PCW){1'b0}}, br_target};
    cval[1] = run && want_pc;
    cand[2] = {1'b0, T_LC, 1'b0, {(28-TCW){1'b0}}, loop_trips};
    cval[2] = run && loop_start;
  end

  assign space = DEPTH_C - cnt;

  always_comb begin
    nwr  = '0;
    drop = 1'b0;
    for (int k = 0; k < 3; k++) begin
      pos[k] = wptr + nwr[AW-1:0];
      we[k]  = cval[k] && (nwr < space);
      if (cval[k] && !we[k]) drop = 1'b1;
      nwr = nwr + CW'(we[k]);
    end
  end

  assign m_tvalid = cnt != '0;
  assign m_tdata  = mem[rptr][31:0];
  assign m_tlast  = mem[rptr][32];
  assign pop      = m_tvalid && m_tready;
  assign ovf      = ovf_q;

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++)
      if (we[k]) mem[pos[k]] <= cand[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      acnt  <= '0;
      abits <= '0;
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      wptr <= wptr + nwr[AW-1:0];
      rptr <= rptr + AW'(pop);
      cnt  <= cnt + nwr - CW'(pop);
      if (start_ev)     ovf_q <= drop;
      else if (drop)    ovf_q <= 1'b1;
      if (start_ev) begin
        act <= 1'b1; acnt <= '0; abits <= '0;
      end else if (stop_ev) begin
        act <= 1'b0; acnt <= '0; abits <= '0;
      end else if (run) begin
        acnt  <= flush ? 4'd0 : n_cnt;
        abits <= flush ? 8'd0 : n_bits;
      end
    end
  end
endmodule

module brtrace_enc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trc_start,
  input logic        act,
  input logic [3:0]  nwr,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic [31:0] m_tdata,
  input logic        m_tlast,
  input logic        ovf
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
  p_lc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tdata[31:29] == 3'b100 |-> !m_tdata[28]);
  p_atom_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tdata[31:29] == 3'b010 |-> m_tdata[27:24] <= 4'd8);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act && !trc_start |-> nwr == 4'd0);
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(trc_start && !act) |=> ovf);
  p_tlast_atom_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tlast |-> m_tdata[31:29] == 3'b010);
endmodule

bind brtrace_enc brtrace_enc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .trc_start(trc_start), .act(act), .nwr(4'(nwr)),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tlast(m_tlast), .ovf(ovf)
);

// File: tb/brtrace_enc_tb.sv
module brtrace_enc_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        trc_start = 0, trc_stop = 0, br_valid = 0, br_taken = 0, loop_start = 0;
  logic [13:0] fetch_pc = 0, br_target = 0;
  logic [2:0]  br_kind = 0;
  logic [27:0] loop_trips = 0;
  logic        m_tvalid, m_tready = 1, m_tlast, ovf;
  logic [31:0] m_tdata;

  int errors = 0, checks = 0;
  logic [32:0] exp_q[$], got_q[$];
  bit        m_act = 0;
  int        m_cnt = 0;
  logic [7:0] m_bits = 0;

  always #10 clk = ~clk;

  brtrace_enc dut_i (.*);

  always @(negedge clk)
    if (rst_n && m_tvalid && m_tready) got_q.push_back({m_tlast, m_tdata});

  function automatic logic [32:0] f_atom(bit last, int c, logic [7:0] b);
    return {last, 3'b010, 1'b0, 4'(c), 16'b0, b};
  endfunction

  function automatic string req_of(logic [32:0] f);
    case (f[31:29])
      3'b001: return "R2";
      3'b011: return "R5";
      3'b100: return "R7";
      default: return f[32] ? "R9" : "R3";
    endcase
  endfunction

  task automatic chk(bit ok, string r, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(bit st, bit sp, logic [13:0] fpc, bit bv, logic [2:0] k,
                      bit tk, logic [13:0] tg, bit ls, logic [27:0] tr);
    bit cnd, pc;
    @(posedge clk); #2;
    trc_start = st; trc_stop = sp; fetch_pc = fpc; br_valid = bv; br_kind = k;
    br_taken = tk; br_target = tg; loop_start = ls; loop_trips = tr;
    if (st && !m_act) begin
      exp_q.push_back({1'b0, 3'b001, 15'b0, fpc});
      m_act = 1; m_cnt = 0; m_bits = 0;
    end else if (sp && m_act) begin
      exp_q.push_back(f_atom(1, m_cnt, m_bits));
      m_act = 0; m_cnt = 0; m_bits = 0;
    end else if (m_act) begin
      cnd = bv && (k == 0 || k == 1);
      pc  = bv && (k == 3 || k == 4);
      if (cnd) begin m_bits[m_cnt] = tk; m_cnt++; end
      if (m_cnt != 0 && (m_cnt == 8 || pc || ls)) begin
        exp_q.push_back(f_atom(0, m_cnt, m_bits)); m_cnt = 0; m_bits = 0;
      end
      if (pc) exp_q.push_back({1'b0, 3'b011, 15'b0, tg});
      if (ls) exp_q.push_back({1'b0, 3'b100, 1'b0, tr});
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic br(logic [2:0] k, bit tk, logic [13:0] tg);
    step(0, 0, 0, 1, k, tk, tg, 0, 0);
  endtask

  task automatic compare(string r);
    int n;
    idle(12);
    checks++;
    if (got_q.size() != exp_q.size()) begin
      errors++;
      $display("FAIL %s frame count actual=%0d expected=%0d", r, got_q.size(), exp_q.size());
    end
    n = got_q.size() < exp_q.size() ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(got_q[i] == exp_q[i], req_of(exp_q[i]), got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!m_tvalid && !ovf, "R1", {31'b0, m_tvalid, ovf}, 33'b0);

    // R9: idle events ignored; R2 anchor is fetch_pc
    br(3'd4, 1, 14'h0123);
    step(0, 0, 0, 0, 0, 0, 0, 1, 28'h55);
    step(1, 0, 14'h1ABC, 1, 3'd3, 1, 14'h0777, 1, 28'h9);
    compare("R2");

    // R3 R4 R5 R8: atoms, direct jump silent, return flushes
    br(3'd0, 1, 0); br(3'd0, 0, 0); br(3'd2, 1, 14'h0200); br(3'd0, 1, 0);
    br(3'd4, 1, 14'h3FFF);
    // R6: conditional indirect -> atom only; R3: full frame of 8
    br(3'd1, 1, 14'h0AAA);
    for (int i = 0; i < 7; i++) br(3'd0, i[0], 0);
    br(3'd3, 0, 14'h0042);
    // R7 R8: cond + loop same cycle
    br(3'd1, 0, 14'h0111);
    step(0, 0, 0, 1, 3'd0, 1, 0, 1, 28'hFFFFFFF);
    step(0, 0, 0, 1, 3'd4, 1, 14'h0010, 1, 28'h1);
    // R9: stop with two pending atoms, then ignored events
    br(3'd0, 1, 0); br(3'd1, 0, 0);
    step(0, 1, 0, 1, 3'd4, 1, 14'h0999, 0, 0);
    br(3'd3, 1, 14'h0005);
    compare("R8");

    // R9: stop with nothing pending -> empty atom frame with TLAST
    step(1, 0, 14'h0001, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    compare("R9");

    // R10: overflow with sink stalled
    m_tready = 0;
    step(1, 0, 14'h0300, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) br(3'd3, 0, 14'(i + 1));
    idle(1);
    @(negedge clk);
    chk(ovf, "R10", {32'b0, ovf}, 33'b1);
    while (exp_q.size() > 8) void'(exp_q.pop_back());
    m_tready = 1;
    idle(2);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    compare("R10");
    @(negedge clk);
    chk(ovf, "R10", {32'b0, ovf}, 33'b1);
    step(1, 0, 14'h0002, 0, 0, 0, 0, 0, 0);
    idle(1);
    @(negedge clk);
    chk(!ovf, "R10", {32'b0, ovf}, 33'b0);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    compare("R10");

    // R11 and random: stalls, mixed events
    step(1, 0, 14'h2222, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      bit bv, ls;
      bv = ($urandom % 4) == 0;
      ls = ($urandom % 20) == 0;
      m_tready = ($urandom % 8) != 0;
      step(0, 0, 0, bv, 3'($urandom % 5), 1'($urandom), 14'($urandom),
           ls, 28'($urandom));
      if (i % 500 == 499) begin
        step(0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 14'($urandom), 0, 0, 0, 0, 0, 0);
      end
    end
    m_tready = 1;
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    compare("R3");
    @(negedge clk);
    chk(!ovf, "R10", {32'b0, ovf}, 33'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule